// File: doc/BRIEF.md
# Standby and sleep mode controller

This block decides what the processor does when its core executes a sleep instruction. A byte-wide control register, reached through a small register bus port, holds two live bits. The standby-enable bit picks the target of a sleep request: light sleep or full standby. The port-float bit picks how the I/O ports behave in standby: they either keep their last values or are released to high impedance. Both bits are locked against the watchdog. While the watchdog timer-enable input is high, a write that tries to set either bit to 1 leaves that bit unchanged.

A state machine follows the sleep-request strobe from the core and the interrupt wake input. It has four states. `ST_RUN` is normal operation. `ST_SLEEP` is light sleep. `ST_STBY_KEEP` is standby with the port values held. `ST_STBY_HIZ` is standby with the ports floated. There are five transitions. `ST_RUN` goes to `ST_SLEEP` on a sleep request when the standby-enable bit is 0. `ST_RUN` goes to `ST_STBY_KEEP` on a sleep request when standby is enabled and the port-float bit is 0. `ST_RUN` goes to `ST_STBY_HIZ` on a sleep request when both bits are 1. Any of the three low-power states returns to `ST_RUN` on a wake interrupt. Reset returns every state to `ST_RUN`.

From the state, the block drives a mode code and two per-port control vectors: output-enable-off and hold. These go to the port logic and to the clock-control logic, which sit outside this block.

Top module: `pwrdn_ctrl`

## Requirements
- R1: During and after reset, the mode output is run (2'b00), every port output-enable-off and hold bit is 0, read data is 0x00, and the register reads back as 0x1F.
- R2: A read strobe (select high, write low) puts the register value on the read data output one clock later. Read data keeps that value until the next read strobe.
- R3: A write with data bit 7 = 1 sets the standby-enable bit (bit 7) only when the watchdog enable input is low. Otherwise the bit keeps its value.
- R4: A write with data bit 6 = 1 sets the port-float bit (bit 6) only when the watchdog enable input is low. Otherwise the bit keeps its value.
- R5: A write with data bit 7 or bit 6 = 0 clears that bit, whatever the watchdog enable input is.
- R6: Register bits 5..0 are read-only. They always read 6'b011111, and write data in those positions has no effect.
- R7: In run, a sleep request moves the block on the next clock. The target is chosen from the register value held before that edge. Sleep is mode code 2'b01, chosen when bit 7 = 0. Standby is mode code 2'b10, chosen when bit 7 = 1. A sleep request in the same cycle as a wake input still enters the low-power state.
- R8: In sleep or standby, a wake input returns the mode to run (2'b00) on the next clock. A sleep request in those states has no effect.
- R9: Bit 6 is captured when standby is entered. Captured 1 asserts every output-enable-off bit and no hold bit. Captured 0 asserts every hold bit and no output-enable-off bit. Writes to bit 6 during standby do not change either output. Outside standby, both vectors are 0.
- R10: An asserted reset takes the block out of standby (or sleep) to run, and restores the register to 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read (when selected) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after a read strobe |
| sleep_req | input | 1 | Sleep-instruction strobe from the core |
| wdt_run | input | 1 | Watchdog timer-enable level |
| wake_irq | input | 1 | Interrupt wake request |
| mode_o | output | 2 | 00 run, 01 sleep, 10 standby |
| port_oe_off | output | NUM_PORTS | Per-port drivers off (standby, float selected) |
| port_hold | output | NUM_PORTS | Per-port value hold (standby, keep selected) |

## Verification
The assertions assume that every input is stable around the rising edge and that `wdt_run` is a level, not a pulse timed to one write. They do not assume that `sleep_req` and `wake_irq` are exclusive, and the stimulus drives both together on purpose. All inputs are driven on the falling edge. Directed sequences come first, covering interlocked writes, entry with each bit setting, writes during standby and reset out of standby. A phase of random traffic follows, in which the watchdog level, register accesses and strobes change every cycle.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    localparam int unsigned CTRL_W  = 8;
    localparam int unsigned SBY_BIT = 7;
    localparam int unsigned HIZ_BIT = 6;
    localparam int unsigned RO_W    = CTRL_W - 2;
    localparam logic [RO_W-1:0] RO_VALUE = 6'b01_1111;

    typedef enum logic [1:0] {
        ST_RUN       = 2'b00,
        ST_SLEEP     = 2'b01,
        ST_STBY_KEEP = 2'b10,
        ST_STBY_HIZ  = 2'b11
    } pd_state_e;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'b00,
        MODE_SLEEP   = 2'b01,
        MODE_STANDBY = 2'b10
    } pd_mode_e;

endpackage

// File: rtl/pwrdn_regfile.sv
module pwrdn_regfile
    import pwrdn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              wdt_run,
    output logic [CTRL_W-1:0] rdata,
    output logic              sby,
    output logic              hiz
);

    logic              sby_q, hiz_q;
    logic              sby_d, hiz_d;
    logic [CTRL_W-1:0] reg_view;
    logic              unused_ro_wdata;

    assign unused_ro_wdata = ^wdata[RO_W-1:0];
    assign reg_view        = {sby_q, hiz_q, RO_VALUE};

    // A 1 is accepted only while the watchdog is stopped; a 0 always lands.
    always_comb begin
        sby_d = sby_q;
        hiz_d = hiz_q;
        if (cs && wr) begin
            if (!wdata[SBY_BIT])  sby_d = 1'b0;
            else if (!wdt_run)    sby_d = 1'b1;
            if (!wdata[HIZ_BIT])  hiz_d = 1'b0;
            else if (!wdt_run)    hiz_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sby_q <= 1'b0;
            hiz_q <= 1'b0;
            rdata <= '0;
        end else begin
            sby_q <= sby_d;
            hiz_q <= hiz_d;
            if (cs && !wr) rdata <= reg_view;
        end
    end

    assign sby = sby_q;
    assign hiz = hiz_q;

    a_r3_no_set_while_wdt: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && !sby_q) |=> !sby_q);

    a_r4_no_float_while_wdt: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_run && !hiz_q) |=> !hiz_q);

    a_r5_clear_always: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !wdata[SBY_BIT]) |=> !sby_q);

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !wr) |=> (rdata == $past(reg_view)));

    a_r6_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !wr) |=> (rdata[RO_W-1:0] == RO_VALUE));

endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
    import pwrdn_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic      wake_irq,
    input  logic      sby,
    input  logic      hiz,
    output pd_state_e state
);

    pd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req) begin
                    if (!sby)     state_d = ST_SLEEP;
                    else if (hiz) state_d = ST_STBY_HIZ;
                    else          state_d = ST_STBY_KEEP;
                end
            end
            ST_SLEEP:     if (wake_irq) state_d = ST_RUN;
            ST_STBY_KEEP: if (wake_irq) state_d = ST_RUN;
            ST_STBY_HIZ:  if (wake_irq) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    assign state = state_q;

    a_r7_leave_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req) |=> (state_q != ST_RUN));

    a_r7_sleep_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && sleep_req && !sby) |=> (state_q == ST_SLEEP));

    a_r8_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && wake_irq) |=> (state_q == ST_RUN));

    a_r8_hold_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !wake_irq) |=> $stable(state_q));

endmodule

// File: rtl/pwrdn_port_drv.sv
module pwrdn_port_drv
    import pwrdn_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8
) (
    input  pd_state_e            state,
    output logic [1:0]           mode,
    output logic [NUM_PORTS-1:0] oe_off,
    output logic [NUM_PORTS-1:0] hold
);

    logic stby_float, stby_keep;

    always_comb begin
        mode       = MODE_RUN;
        stby_float = 1'b0;
        stby_keep  = 1'b0;
        unique case (state)
            ST_RUN:       mode = MODE_RUN;
            ST_SLEEP:     mode = MODE_SLEEP;
            ST_STBY_KEEP: begin mode = MODE_STANDBY; stby_keep  = 1'b1; end
            ST_STBY_HIZ:  begin mode = MODE_STANDBY; stby_float = 1'b1; end
            default:      mode = MODE_RUN;
        endcase
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        assign oe_off[g] = stby_float;
        assign hold[g]   = stby_keep;
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_cs,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic                 sleep_req,
    input  logic                 wdt_run,
    input  logic                 wake_irq,
    output logic [1:0]           mode_o,
    output logic [NUM_PORTS-1:0] port_oe_off,
    output logic [NUM_PORTS-1:0] port_hold
);

    logic      sby, hiz;
    pd_state_e state;

    pwrdn_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (bus_cs),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .wdt_run (wdt_run),
        .rdata   (bus_rdata),
        .sby     (sby),
        .hiz     (hiz)
    );

    pwrdn_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_irq  (wake_irq),
        .sby       (sby),
        .hiz       (hiz),
        .state     (state)
    );

    pwrdn_port_drv #(.NUM_PORTS(NUM_PORTS)) u_ports (
        .state  (state),
        .mode   (mode_o),
        .oe_off (port_oe_off),
        .hold   (port_hold)
    );

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (port_oe_off & port_hold) == '0);

    a_r9_only_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != MODE_STANDBY) |-> (port_oe_off == '0 && port_hold == '0));

    a_r9_float_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STANDBY && !wake_irq) |=> $stable(port_oe_off));

endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  NP         = 8;
    localparam int  WD_CYCLES  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs = 0, bus_wr = 0, sleep_req = 0, wdt_run = 0, wake_irq = 0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [1:0]    mode_o;
    logic [NP-1:0] port_oe_off, port_hold;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int         m_mode = 0;   // 0 run, 1 sleep, 2 standby
    bit         m_lat  = 0;
    bit         m_sby  = 0;
    bit         m_hiz  = 0;
    logic [7:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_ctrl #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .wdt_run(wdt_run), .wake_irq(wake_irq), .mode_o(mode_o),
        .port_oe_off(port_oe_off), .port_hold(port_hold)
    );

    task automatic chk(input string what, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [1:0]    e_mode;
        logic [NP-1:0] e_oe, e_hold;
        e_mode = 2'(m_mode);
        e_oe   = (m_mode == 2 &&  m_lat) ? '1 : '0;
        e_hold = (m_mode == 2 && !m_lat) ? '1 : '0;
        chk("mode",   tag, 32'(mode_o),      32'(e_mode));
        chk("oe_off", tag, 32'(port_oe_off), 32'(e_oe));
        chk("hold",   tag, 32'(port_hold),   32'(e_hold));
        chk("rdata",  tag, 32'(bus_rdata),   32'(m_rdata));
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input logic cs, input logic wr, input logic [7:0] wd,
                        input logic slp, input logic wdt, input logic wk,
                        input string tag);
        logic [7:0] view;
        bus_cs = cs; bus_wr = wr; bus_wdata = wd;
        sleep_req = slp; wdt_run = wdt; wake_irq = wk;
        @(posedge clk);
        view = {m_sby, m_hiz, 6'b011111};
        if (cs && !wr) m_rdata = view;
        if (m_mode == 0) begin
            if (slp) begin
                m_mode = m_sby ? 2 : 1;
                m_lat  = m_hiz;
            end
        end else if (wk) begin
            m_mode = 0;
        end
        if (cs && wr) begin
            if (!wd[7]) m_sby = 0; else if (!wdt) m_sby = 1;
            if (!wd[6]) m_hiz = 0; else if (!wdt) m_hiz = 1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic rd(input string tag);
        step(1, 0, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic wrt(input logic [7:0] d, input logic wdt, input string tag);
        step(1, 1, d, 0, wdt, 0, tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 0;
        bus_cs = 0; bus_wr = 0; sleep_req = 0; wake_irq = 0; wdt_run = 0;
        m_mode = 0; m_lat = 0; m_sby = 0; m_hiz = 0; m_rdata = '0;
        #1;
        compare(tag);
        @(negedge clk);
        compare(tag);
        rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset("R1");
        rd("R1");                         // reads 0x1F
        // interlock
        wrt(8'hC0, 1, "R3"); rd("R4");    // refused -> 1F
        wrt(8'h80, 0, "R3"); rd("R3");    // 9F
        wrt(8'hFF, 0, "R6"); rd("R6");    // DF, bits 5..0 unchanged
        wrt(8'h00, 1, "R5"); rd("R5");    // 1F
        wrt(8'hC0, 0, "R4");
        wrt(8'h40, 1, "R5"); rd("R5");    // bit 7 cleared, bit 6 kept -> 5F
        wrt(8'hC0, 1, "R3"); rd("R3");    // bit 7 refused -> 5F
        wrt(8'h00, 0, "R5"); rd("R2"); idle("R2"); idle("R2");
        // sleep path
        step(0, 0, 8'h00, 1, 0, 0, "R7");
        idle("R8");
        step(0, 0, 8'h00, 1, 0, 0, "R8"); // ignored in sleep
        step(0, 0, 8'h00, 0, 0, 1, "R8");
        idle("R8");
        // standby with float
        wrt(8'hC0, 0, "R9");
        step(0, 0, 8'h00, 1, 0, 0, "R7");
        wrt(8'h80, 0, "R9");              // clear bit 6 during standby
        idle("R9"); rd("R9");
        step(0, 0, 8'h00, 0, 0, 1, "R8");
        idle("R9");
        // standby with hold, left by reset
        step(0, 0, 8'h00, 1, 0, 0, "R7");
        wrt(8'hC0, 0, "R9"); idle("R9");
        do_reset("R10");
        rd("R10"); idle("R10");
        // sleep request together with wake in run
        step(0, 0, 8'h00, 1, 0, 1, "R7");
        step(0, 0, 8'h00, 0, 0, 1, "R8");
        // random traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            step(r[0] & r[1], r[2], 8'(r[15:8]), (r[19:16] == 0),
                 r[20] & r[21], (r[25:22] == 0), "R7");
        end
        idle("R8");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule